// File: doc/BRIEF.md
# SD Card Host Command Issue Unit

This block launches commands toward an SD card and collects their outcome. Software loads a 32-bit argument and a timeout limit, then writes a command word whose top flag starts the command phase. The unit emits a one-cycle start strobe toward a separate line engine, which shifts the command out and reports the arrival of a response start bit, response completion and any CRC7 mismatch. The unit then stores a short or long response in a bank of four 32-bit words, optionally waits for the card to drop its busy signal, and clears the launch flag.

Any failure sets a sticky fail flag in the command word and records its cause in a host status word. The status word also gathers events from the data path. Software clears these event bits by writing ones to them. All registers sit on a simple word-addressed write port with a combinational read port. The word indices are: command 0, argument 1, timeout 2, response words 4 to 7 (bits 31:0 up to 127:96), and status 8.

Top module: `sd_cmd_issue`

## Requirements
- R1: The command word keeps the command index in bits 5:0, read-data at bit 6, write-data at bit 7, long response at bit 9, no response at bit 10 and busy wait at bit 11. Reading it returns these fields, plus fail at bit 14 and the launch flag at bit 15. Bits 8, 12, 13 and 31:16 read as zero.
- R2: A command write with bit 15 set, accepted while no command is in flight, raises `eng_start` for exactly one cycle, in the cycle after the write. During that cycle the engine outputs carry the new index, argument and response type.
- R3: The launch flag (bit 15) reads as 1 from the accepted write until the command phase ends, and hardware then clears it. After reset it reads as 0.
- R4: A command write made while the launch flag is set is ignored. The stored fields stay unchanged, no new start strobe is issued, and the running command completes normally.
- R5: A command with bit 10 set finishes in the cycle after its start strobe, without waiting for the engine, and leaves all response words unchanged.
- R6: A short response loads only word index 4 with response bits 31:0. A long response loads indices 4, 5, 6 and 7 with bits 31:0, 63:32, 95:64 and 127:96.
- R7: If no response start bit arrives within the number of cycles held in the timeout register, the command fails. In one cycle the launch flag clears, the fail flag (bit 14) sets and status bit 6 (command timeout) sets.
- R8: A response completed with a CRC7 mismatch fails the command in the same way, and sets status bit 4.
- R9: With busy wait requested and a response present, the launch flag stays set while `card_busy` is high after the response. Once `card_busy` is low, the flag clears and status bit 10 sets.
- R10: Writing to the status word clears each of bits 3 to 10 that has a 1 in the written data. Bits written as 0 keep their value. Bit 0 always mirrors the `data_flag` input.
- R11: The fail flag is sticky. It is cleared only when the next command is launched.
- R12: Pulses on `data_evt` bits 0 to 4 set status bits 3 (FIFO error), 5 (CRC16 error), 7 (data timeout), 8 (SDIO interrupt) and 9 (block interrupt).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word index for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| eng_start | output | 1 | One-cycle command start toward the line engine |
| eng_idx | output | 6 | Command index |
| eng_arg | output | 32 | Command argument |
| eng_long | output | 1 | 136-bit response expected |
| eng_expect_rsp | output | 1 | A response is expected |
| eng_rsp_start | input | 1 | Response start bit seen on the line |
| eng_rsp_done | input | 1 | Response fully received (one-cycle pulse) |
| eng_crc_err | input | 1 | CRC7 mismatch, valid with `eng_rsp_done` |
| eng_rsp | input | 128 | Response content, valid with `eng_rsp_done` |
| card_busy | input | 1 | Card holds its busy indication |
| data_flag | input | 1 | Data path readiness, shown in status bit 0 |
| data_evt | input | 5 | Data-path event pulses for status bits 3, 5, 7, 8, 9 |

## Verification
The bench overlaps a second launch with a command in flight. A unit that wrongly accepted it would show the new index or a second start strobe. The timeout case counts polled cycles, so an off-by-many counter or a comparison that never matches shows up as early completion or as a hang. The busy-wait case holds `card_busy` over several cycles; a design that ignored it would clear the launch flag too early and set bit 10 before the card is released. The status cases write zeros and then selective ones, and they give short and long responses with different word patterns. These catch an inverted clear mask and swapped or extra response writes.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
   // register word indices
   localparam logic [3:0] ADR_CMD  = 4'd0;
   localparam logic [3:0] ADR_ARG  = 4'd1;
   localparam logic [3:0] ADR_TMO  = 4'd2;
   localparam logic [3:0] ADR_RSP0 = 4'd4;
   localparam logic [3:0] ADR_STAT = 4'd8;

   // command word field positions
   localparam int CB_RD     = 6;
   localparam int CB_WR     = 7;
   localparam int CB_LONG   = 9;
   localparam int CB_NORSP  = 10;
   localparam int CB_BUSYW  = 11;
   localparam int CB_FAIL   = 14;
   localparam int CB_NEW    = 15;
   localparam logic [11:0] CMD_KEEP = 12'hEFF;

   // status positions
   localparam int SB_DATA  = 0;
   localparam int SB_FIFO  = 3;
   localparam int SB_CRC7  = 4;
   localparam int SB_CRC16 = 5;
   localparam int SB_CTMO  = 6;
   localparam int SB_DTMO  = 7;
   localparam int SB_SDIO  = 8;
   localparam int SB_BLOCK = 9;
   localparam int SB_BUSY  = 10;
   localparam int STAT_W   = 11;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_ISSUE = 2'd1,
      PH_WAIT  = 2'd2,
      PH_BUSY  = 2'd3
   } phase_t;
endpackage

// File: rtl/sd_cmd_seq.sv
module sd_cmd_seq
   import sd_cmd_pkg::*;
#(
   parameter int TMO_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  logic             no_rsp,
   input  logic             busy_wait,
   input  logic [TMO_W-1:0] tmo_lim,
   input  logic             rsp_start,
   input  logic             rsp_done,
   input  logic             crc_err,
   input  logic             card_busy,
   output logic             start,
   output logic             fin,
   output logic             tmo_evt,
   output logic             crc_evt,
   output logic             busy_evt,
   output logic             capture,
   output logic             busy_phase
);
   phase_t           ph_q, ph_d;
   logic [TMO_W-1:0] cnt_q, cnt_d;
   logic             seen_q, seen_d;

   always_comb begin
      ph_d     = ph_q;
      cnt_d    = cnt_q;
      seen_d   = seen_q;
      fin      = 1'b0;
      tmo_evt  = 1'b0;
      crc_evt  = 1'b0;
      busy_evt = 1'b0;
      capture  = 1'b0;
      unique case (ph_q)
         PH_IDLE: begin
            if (launch) ph_d = PH_ISSUE;
         end
         PH_ISSUE: begin
            cnt_d  = '0;
            seen_d = 1'b0;
            if (no_rsp) begin
               fin  = 1'b1;
               ph_d = PH_IDLE;
            end else begin
               ph_d = PH_WAIT;
            end
         end
         PH_WAIT: begin
            if (rsp_done) begin
               capture = 1'b1;
               if (crc_err) begin
                  fin     = 1'b1;
                  crc_evt = 1'b1;
                  ph_d    = PH_IDLE;
               end else if (busy_wait) begin
                  ph_d = PH_BUSY;
               end else begin
                  fin  = 1'b1;
                  ph_d = PH_IDLE;
               end
            end else if (!seen_q && rsp_start) begin
               seen_d = 1'b1;
            end else if (!seen_q && cnt_q == tmo_lim) begin
               fin     = 1'b1;
               tmo_evt = 1'b1;
               ph_d    = PH_IDLE;
            end else if (!seen_q) begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         PH_BUSY: begin
            if (!card_busy) begin
               fin      = 1'b1;
               busy_evt = 1'b1;
               ph_d     = PH_IDLE;
            end
         end
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         seen_q <= 1'b0;
      end else begin
         ph_q   <= ph_d;
         cnt_q  <= cnt_d;
         seen_q <= seen_d;
      end
   end

   assign start      = (ph_q == PH_ISSUE);
   assign busy_phase = (ph_q == PH_BUSY);
endmodule

// File: rtl/sd_cmd_rsp.sv
module sd_cmd_rsp #(
   parameter int WORDS  = 4,
   parameter int WORD_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    capture,
   input  logic                    is_long,
   input  logic [WORDS*WORD_W-1:0] rsp_in,
   output logic [WORDS*WORD_W-1:0] rsp_q
);
   genvar gi;
   generate
      for (gi = 0; gi < WORDS; gi++) begin : g_word
         logic load;
         if (gi == 0) begin : g_low
            assign load = capture;
         end else begin : g_high
            assign load = capture & is_long;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    rsp_q[gi*WORD_W +: WORD_W] <= '0;
            else if (load) rsp_q[gi*WORD_W +: WORD_W] <= rsp_in[gi*WORD_W +: WORD_W];
         end
      end
   endgenerate
endmodule

// File: rtl/sd_cmd_status.sv
module sd_cmd_status
   import sd_cmd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] set_vec,
   input  logic              clr_wr,
   input  logic [STAT_W-1:0] clr_mask,
   input  logic              data_flag,
   output logic [STAT_W-1:0] stat_q
);
   assign stat_q[SB_DATA] = data_flag;
   assign stat_q[2:1]     = 2'b00;

   genvar gb;
   generate
      for (gb = SB_FIFO; gb < STAT_W; gb++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               stat_q[gb] <= 1'b0;
            else if (set_vec[gb])
               stat_q[gb] <= 1'b1;
            else if (clr_wr && clr_mask[gb])
               stat_q[gb] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/sd_cmd_issue.sv
module sd_cmd_issue
   import sd_cmd_pkg::*;
#(
   parameter int          WORD_W    = 32,
   parameter int          RSP_WORDS = 4,
   parameter int          TMO_W     = 32,
   parameter logic [31:0] TMO_RESET = 32'h00F0_0000
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        reg_wr,
   input  logic [3:0]                  reg_addr,
   input  logic [WORD_W-1:0]           reg_wdata,
   output logic [WORD_W-1:0]           reg_rdata,
   output logic                        eng_start,
   output logic [5:0]                  eng_idx,
   output logic [WORD_W-1:0]           eng_arg,
   output logic                        eng_long,
   output logic                        eng_expect_rsp,
   input  logic                        eng_rsp_start,
   input  logic                        eng_rsp_done,
   input  logic                        eng_crc_err,
   input  logic [RSP_WORDS*WORD_W-1:0] eng_rsp,
   input  logic                        card_busy,
   input  logic                        data_flag,
   input  logic [4:0]                  data_evt
);
   localparam int RSP_W = RSP_WORDS * WORD_W;

   generate
      if (WORD_W != 32 || RSP_W != 128) begin : g_bad_shape
         $error("sd_cmd_issue: response bank must be four 32-bit words");
      end
      if (TMO_W < 1 || TMO_W > WORD_W) begin : g_bad_tmo
         $error("sd_cmd_issue: TMO_W out of range");
      end
   endgenerate

   logic [11:0]       cmd_q;
   logic              cmd_new, cmd_fail;
   logic [WORD_W-1:0] arg_q;
   logic [TMO_W-1:0]  tmo_q;
   logic [RSP_W-1:0]  rsp_q;
   logic [STAT_W-1:0] stat_q, set_vec;
   logic              cmd_acc, launch;
   logic              fin, tmo_evt, crc_evt, busy_evt, capture, busy_phase;

   assign cmd_acc = reg_wr && (reg_addr == ADR_CMD) && !cmd_new;
   assign launch  = cmd_acc && reg_wdata[CB_NEW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q    <= '0;
         cmd_new  <= 1'b0;
         cmd_fail <= 1'b0;
         arg_q    <= '0;
         tmo_q    <= TMO_W'(TMO_RESET);
      end else begin
         if (cmd_acc) cmd_q <= reg_wdata[11:0] & CMD_KEEP;
         if (launch)   cmd_new <= 1'b1;
         else if (fin) cmd_new <= 1'b0;
         if (launch)                 cmd_fail <= 1'b0;
         else if (tmo_evt | crc_evt) cmd_fail <= 1'b1;
         if (reg_wr && reg_addr == ADR_ARG) arg_q <= reg_wdata;
         if (reg_wr && reg_addr == ADR_TMO) tmo_q <= reg_wdata[TMO_W-1:0];
      end
   end

   sd_cmd_seq #(.TMO_W(TMO_W)) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch     (launch),
      .no_rsp     (cmd_q[CB_NORSP]),
      .busy_wait  (cmd_q[CB_BUSYW]),
      .tmo_lim    (tmo_q),
      .rsp_start  (eng_rsp_start),
      .rsp_done   (eng_rsp_done),
      .crc_err    (eng_crc_err),
      .card_busy  (card_busy),
      .start      (eng_start),
      .fin        (fin),
      .tmo_evt    (tmo_evt),
      .crc_evt    (crc_evt),
      .busy_evt   (busy_evt),
      .capture    (capture),
      .busy_phase (busy_phase)
   );

   sd_cmd_rsp #(.WORDS(RSP_WORDS), .WORD_W(WORD_W)) rsp_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .is_long (cmd_q[CB_LONG]),
      .rsp_in  (eng_rsp),
      .rsp_q   (rsp_q)
   );

   always_comb begin
      set_vec           = '0;
      set_vec[SB_FIFO]  = data_evt[0];
      set_vec[SB_CRC16] = data_evt[1];
      set_vec[SB_DTMO]  = data_evt[2];
      set_vec[SB_SDIO]  = data_evt[3];
      set_vec[SB_BLOCK] = data_evt[4];
      set_vec[SB_CRC7]  = crc_evt;
      set_vec[SB_CTMO]  = tmo_evt;
      set_vec[SB_BUSY]  = busy_evt;
   end

   sd_cmd_status stat_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_vec   (set_vec),
      .clr_wr    (reg_wr && reg_addr == ADR_STAT),
      .clr_mask  (reg_wdata[STAT_W-1:0]),
      .data_flag (data_flag),
      .stat_q    (stat_q)
   );

   assign eng_idx        = cmd_q[5:0];
   assign eng_arg        = arg_q;
   assign eng_long       = cmd_q[CB_LONG];
   assign eng_expect_rsp = !cmd_q[CB_NORSP];

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADR_CMD)
         reg_rdata = {16'b0, cmd_new, cmd_fail, 2'b00, cmd_q};
      else if (reg_addr == ADR_ARG)
         reg_rdata = arg_q;
      else if (reg_addr == ADR_TMO)
         reg_rdata = WORD_W'(tmo_q);
      else if (reg_addr == ADR_STAT)
         reg_rdata = WORD_W'(stat_q);
      else
         for (int i = 0; i < RSP_WORDS; i++)
            if (32'(reg_addr) == 32'(ADR_RSP0) + i)
               reg_rdata = rsp_q[i*WORD_W +: WORD_W];
   end
endmodule

// File: rtl/sd_cmd_issue_chk.sv
module sd_cmd_issue_chk
   import sd_cmd_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [3:0]        reg_addr,
   input logic [31:0]       reg_wdata,
   input logic              eng_start,
   input logic              cmd_new,
   input logic              cmd_fail,
   input logic [11:0]       cmd_q,
   input logic              tmo_evt,
   input logic              crc_evt,
   input logic              busy_phase,
   input logic              card_busy,
   input logic [4:0]        data_evt,
   input logic [STAT_W-1:0] stat_q
);
   // R2: accepted launch gives a start strobe in the next cycle
   a_r2_start_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADR_CMD && !cmd_new && reg_wdata[CB_NEW]) |=> eng_start);

   // R2: the strobe lasts one cycle
   a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);

   // R4: a command write during flight leaves the fields alone
   a_r4_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADR_CMD && cmd_new) |=> $stable(cmd_q));

   // R7, R8: failure ends the command and raises fail together
   a_r7_fail_clears_new: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_evt || crc_evt) |=> (cmd_fail && !cmd_new));

   // R7: a failure only happens to a command in flight
   a_r7_fail_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_evt || crc_evt) |-> cmd_new);

   // R9: card busy holds the launch flag
   a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_phase && card_busy) |=> cmd_new);

   // R10: writing one to FIFO error bit clears it when no new event
   a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADR_STAT && reg_wdata[SB_FIFO] && !data_evt[0])
      |=> !stat_q[SB_FIFO]);
endmodule

bind sd_cmd_issue sd_cmd_issue_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .eng_start  (eng_start),
   .cmd_new    (cmd_new),
   .cmd_fail   (cmd_fail),
   .cmd_q      (cmd_q),
   .tmo_evt    (tmo_evt),
   .crc_evt    (crc_evt),
   .busy_phase (busy_phase),
   .card_busy  (card_busy),
   .data_evt   (data_evt),
   .stat_q     (stat_q)
);

// File: tb/sd_cmd_issue_tb.sv
module sd_cmd_issue_tb_top;
   localparam time CLK_PERIOD = 10ns;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_wr = 1'b0;
   logic [3:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic         eng_start, eng_long, eng_expect_rsp;
   logic [5:0]   eng_idx;
   logic [31:0]  eng_arg;
   logic         eng_rsp_start = 1'b0, eng_rsp_done = 1'b0, eng_crc_err = 1'b0;
   logic [127:0] eng_rsp = '0;
   logic         card_busy = 1'b0, data_flag = 1'b0;
   logic [4:0]   data_evt = '0;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sd_cmd_issue dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_start(eng_start),
      .eng_idx(eng_idx), .eng_arg(eng_arg), .eng_long(eng_long),
      .eng_expect_rsp(eng_expect_rsp), .eng_rsp_start(eng_rsp_start),
      .eng_rsp_done(eng_rsp_done), .eng_crc_err(eng_crc_err), .eng_rsp(eng_rsp),
      .card_busy(card_busy), .data_flag(data_flag), .data_evt(data_evt)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic give_rsp(input logic [127:0] r, input logic crc);
      @(negedge clk);
      eng_rsp_start = 1'b1;
      @(negedge clk);
      eng_rsp_start = 1'b0;
      eng_rsp = r; eng_crc_err = crc; eng_rsp_done = 1'b1;
      @(negedge clk);
      eng_rsp_done = 1'b0; eng_crc_err = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(4'd0, v); chk("R3 reset cmd", v, 32'h0);
      rd(4'd8, v); chk("R10 reset status", v, 32'h0);
      rd(4'd4, v); chk("R6 reset rsp0", v, 32'h0);
      chk("R2 no strobe at reset", 32'(eng_start), 32'h0);
   endtask

   task automatic t_noresp();
      logic [31:0] v;
      wr(4'd0, 32'h0000_8445);
      chk("R2 strobe", 32'(eng_start), 32'h1);
      chk("R2 index", 32'(eng_idx), 32'd5);
      chk("R5 expect flag", 32'(eng_expect_rsp), 32'h0);
      rd(4'd0, v); chk("R1 R5 fields after finish", v, 32'h0000_0445);
      rd(4'd4, v); chk("R5 rsp0 untouched", v, 32'h0);
   endtask

   task automatic t_short();
      logic [31:0] v;
      wr(4'd1, 32'h1234_5678);
      wr(4'd0, 32'h0000_8011);
      chk("R2 arg", eng_arg, 32'h1234_5678);
      chk("R2 short type", 32'(eng_long), 32'h0);
      rd(4'd0, v); chk("R3 new while waiting", v[15], 1'b1);
      give_rsp({32'hAAAA_0003, 32'hAAAA_0002, 32'hAAAA_0001, 32'hCAFE_0900}, 1'b0);
      rd(4'd0, v); chk("R3 new cleared", v, 32'h0000_0011);
      rd(4'd4, v); chk("R6 short rsp0", v, 32'hCAFE_0900);
      rd(4'd5, v); chk("R6 short rsp1 untouched", v, 32'h0);
   endtask

   task automatic t_long();
      logic [31:0] v;
      wr(4'd0, 32'h0000_8202);
      chk("R2 long type", 32'(eng_long), 32'h1);
      give_rsp({32'hD003_0003, 32'hD002_0002, 32'hD001_0001, 32'hD000_0000}, 1'b0);
      rd(4'd4, v); chk("R6 long w0", v, 32'hD000_0000);
      rd(4'd5, v); chk("R6 long w1", v, 32'hD001_0001);
      rd(4'd6, v); chk("R6 long w2", v, 32'hD002_0002);
      rd(4'd7, v); chk("R6 long w3", v, 32'hD003_0003);
   endtask

   task automatic t_ignored();
      logic [31:0] v;
      wr(4'd0, 32'h0000_8002);
      wr(4'd0, 32'h0000_8409);
      chk("R4 no second strobe", 32'(eng_start), 32'h0);
      rd(4'd0, v); chk("R4 fields kept", v, 32'h0000_8002);
      give_rsp(128'h0, 1'b0);
      rd(4'd0, v); chk("R4 first command completes", v, 32'h0000_0002);
   endtask

   task automatic t_timeout();
      logic [31:0] v;
      int n;
      wr(4'd2, 32'd10);
      wr(4'd0, 32'h0000_8003);
      n = 0;
      v = 32'h8000;
      while (v[15] && n < 60) begin
         rd(4'd0, v);
         n++;
      end
      checks++;
      if (n < 10 || n > 16) begin
         errors++;
         $display("FAIL R7 timeout length: got %0d expected 10..16", n);
      end
      chk("R7 fail set new clear", v, 32'h0000_4003);
      rd(4'd8, v); chk("R7 status timeout", v, 32'h0000_0040);
      wr(4'd8, 32'h0);
      rd(4'd8, v); chk("R10 zero write keeps", v, 32'h0000_0040);
      wr(4'd8, 32'h0000_0040);
      rd(4'd8, v); chk("R10 one write clears", v, 32'h0);
      rd(4'd0, v); chk("R11 fail still sticky", v[14], 1'b1);
      wr(4'd2, 32'h00F0_0000);
   endtask

   task automatic t_relaunch();
      logic [31:0] v;
      wr(4'd0, 32'h0000_8404);
      rd(4'd0, v); chk("R11 fail cleared on launch", v, 32'h0000_0404);
   endtask

   task automatic t_crc();
      logic [31:0] v;
      wr(4'd0, 32'h0000_8001);
      give_rsp(128'h5, 1'b1);
      rd(4'd0, v); chk("R8 fail on crc", v, 32'h0000_4001);
      rd(4'd8, v); chk("R8 status crc7", v, 32'h0000_0010);
      wr(4'd8, 32'h0000_0010);
   endtask

   task automatic t_busy();
      logic [31:0] v;
      card_busy = 1'b1;
      wr(4'd0, 32'h0000_8807);
      give_rsp(128'h7, 1'b0);
      for (int i = 0; i < 5; i++) begin
         rd(4'd0, v); chk("R9 new held while busy", v[15], 1'b1);
      end
      rd(4'd8, v); chk("R9 no busy irq yet", v[10], 1'b0);
      card_busy = 1'b0;
      rd(4'd0, v); chk("R9 new cleared on release", v, 32'h0000_0807);
      rd(4'd8, v); chk("R9 busy irq", v, 32'h0000_0400);
      wr(4'd8, 32'h0000_0400);
   endtask

   task automatic t_events();
      logic [31:0] v;
      data_flag = 1'b1;
      @(negedge clk);
      data_evt = 5'h1F;
      @(negedge clk);
      data_evt = '0;
      rd(4'd8, v); chk("R12 data events", v, 32'h0000_03A9);
      wr(4'd8, 32'h0000_0020);
      rd(4'd8, v); chk("R10 selective clear", v, 32'h0000_0389);
      wr(4'd8, 32'h0000_07F8);
      rd(4'd8, v); chk("R10 clear all keeps data flag", v, 32'h0000_0001);
      data_flag = 1'b0;
      rd(4'd8, v); chk("R10 data flag mirror", v, 32'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_noresp();
      t_short();
      t_long();
      t_ignored();
      t_timeout();
      t_relaunch();
      t_crc();
      t_busy();
      t_events();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule